// File: doc/BRIEF.md
# Frame Alignment Delay Meter

This block measures how far an external evaluation strobe lags the device frame pulse, so that software can choose the per-stream input offsets. It runs on a sampling clock at twice the master clock rate, so one tick of `clk` is half a master clock period. The compared edge depends on the detected line format. In the falling-edge format (frame pulse idles high), falling edges are compared. In the rising-edge format (frame pulse idles low), rising edges are compared.

Software controls the block with a single start level. The start level must be sampled low for a full frame of ticks before a rising transition is accepted. The first reference edge after an accepted start opens a measurement window of ten ticks. The first matching strobe edge in that window fixes the delay. The second reference edge after the start raises the completion flag and presents the coded result. Dropping the start level aborts the measurement or clears a finished one.

The result is coded as whole master periods in bits 2..0 plus bit 11, which is set when there is no extra half period. This is the inverse of the half-period select used when offsets are programmed.

States: `ST_IDLE` (waiting), `ST_SYNC` (started, waiting for the first reference edge), `ST_MEAS` (window open, counting ticks), `ST_HOLD` (delay captured, waiting for the second reference edge), `ST_DONE` (flag and result shown). Transitions: T_ARM IDLE→SYNC on a qualified start rise; T_COINCIDE SYNC→HOLD when the reference and strobe edges share a tick; T_ALIGN SYNC→MEAS on a reference edge alone; T_CATCH MEAS→HOLD on a strobe edge; T_EXPIRE MEAS→HOLD when the count reaches nine; T_FINISH HOLD→DONE on a reference edge; T_ABORT any state→IDLE when start is low.

Top module: `frame_skew_meter`

## Requirements
- R1: After reset, `done_o` is 0 and `result_o` is 0.
- R2: A rising transition of `start_i` begins a measurement only if `start_i` was sampled low on at least FRAME_TICKS consecutive ticks just before it. A shorter low period leaves `done_o` at 0.
- R3: With `gci_i`=0, falling edges of `frame_i` and `fe_i` are compared. With `gci_i`=1, rising edges are compared.
- R4: The delay d is the number of ticks from the first reference edge after the start to the first strobe edge at or after that edge, for d in 0..9. Strobe edges before that reference edge are ignored.
- R5: When `done_o` is 1, `result_o[2:0]` = floor(d/2), `result_o[11]` = 1 if d is even and 0 if d is odd, and `result_o[10:3]` = 0.
- R6: `done_o` rises on the tick of the second reference edge after the accepted start, and the coded result appears on the same tick.
- R7: If no strobe edge falls within ticks 0..9 of the window, d is taken as 9 and `result_o` reads 12'h004.
- R8: A low sample of `start_i` aborts a running measurement and clears `done_o` and `result_o` on that tick.
- R9: `result_o` is 0 whenever `done_o` is 0. `done_o` stays high as long as `start_i` stays high. A new measurement needs a fresh qualified low period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock at twice the master clock rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | Device frame pulse |
| fe_i | input | 1 | External evaluation strobe |
| gci_i | input | 1 | Detected format: 0 compares falling edges, 1 compares rising edges |
| start_i | input | 1 | Start level from the control register |
| done_o | output | 1 | Completion flag |
| result_o | output | 12 | Coded delay: bit 11 is the inverted half bit, bits 2..0 are whole periods |

## Verification
An input change applied between edges is seen at the next rising edge. The flag and result registers change on that same edge, so every result is checked at the falling edge that follows. A bench model counts ticks from the accepted start to each reference edge and strobe edge, and predicts the flag and the code for every tick. Each scenario also checks the flag and code three frames after the start, which covers the two reference edges. After start is dropped, the bench checks one and two ticks later that both outputs have cleared.

// File: rtl/fsk_pkg.sv
package fsk_pkg;
    localparam int RES_W    = 12;
    localparam int HALF_POS = 11;
    localparam int WHOLE_W  = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SYNC,
        ST_MEAS,
        ST_HOLD,
        ST_DONE
    } fsk_state_e;

    // whole periods in the low bits, inverted half flag in the top bit
    function automatic logic [RES_W-1:0] fsk_encode(input logic [7:0] halves);
        logic [RES_W-1:0] r;
        r = '0;
        r[WHOLE_W-1:0] = halves[WHOLE_W:1];
        r[HALF_POS]    = ~halves[0];
        return r;
    endfunction
endpackage

// File: rtl/fsk_edge.sv
module fsk_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    input  logic rise_sel_i,
    output logic hit_o
);
    logic sig_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig_i;
    end

    assign hit_o = rise_sel_i ? (sig_i & ~sig_q) : (~sig_i & sig_q);
endmodule

// File: rtl/fsk_arm.sv
module fsk_arm #(
    parameter int FRAME_TICKS = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic go_o,
    output logic qual_o
);
    localparam int CW = $clog2(FRAME_TICKS + 1);

    logic [CW-1:0] low_cnt;
    logic          start_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt <= '0;
            start_q <= 1'b0;
        end else begin
            start_q <= start_i;
            if (start_i)
                low_cnt <= '0;
            else if (low_cnt != CW'(FRAME_TICKS))
                low_cnt <= low_cnt + 1'b1;
        end
    end

    assign qual_o = (low_cnt == CW'(FRAME_TICKS));
    assign go_o   = start_i & ~start_q & qual_o;

    AST_GO_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        go_o |-> !$past(start_i)); // R2
endmodule

// File: rtl/frame_skew_meter.sv
module frame_skew_meter
    import fsk_pkg::*;
#(
    parameter int FRAME_TICKS = 1024,
    parameter int MAX_HALF    = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_i,
    input  logic             fe_i,
    input  logic             gci_i,
    input  logic             start_i,
    output logic             done_o,
    output logic [RES_W-1:0] result_o
);
    localparam int CNT_W = $clog2(MAX_HALF + 1);
    localparam int N_SIG = 2;

    fsk_state_e       state, nxt;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] half_q;
    logic [N_SIG-1:0] raw, hits;
    logic             ref_hit, fe_hit;
    logic             go, arm_qual;

    assign raw = {fe_i, frame_i};

    for (genvar i = 0; i < N_SIG; i++) begin : g_edge
        fsk_edge u_edge (
            .clk        (clk),
            .rst_n      (rst_n),
            .sig_i      (raw[i]),
            .rise_sel_i (gci_i),
            .hit_o      (hits[i])
        );
    end

    assign ref_hit = hits[0];
    assign fe_hit  = hits[1];

    fsk_arm #(.FRAME_TICKS(FRAME_TICKS)) u_arm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .go_o    (go),
        .qual_o  (arm_qual)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (go) nxt = ST_SYNC;                                  // T_ARM
            ST_SYNC: if (ref_hit) nxt = fe_hit ? ST_HOLD : ST_MEAS;          // T_COINCIDE / T_ALIGN
            ST_MEAS: if (fe_hit || cnt_q == CNT_W'(MAX_HALF)) nxt = ST_HOLD; // T_CATCH / T_EXPIRE
            ST_HOLD: if (ref_hit) nxt = ST_DONE;                             // T_FINISH
            ST_DONE: nxt = ST_DONE;
            default: nxt = ST_IDLE;
        endcase
        if (!start_i) nxt = ST_IDLE;                                         // T_ABORT
    end

    // window counter and captured delay
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            half_q <= '0;
        end else begin
            unique case (state)
                ST_SYNC: if (ref_hit) begin
                    cnt_q  <= CNT_W'(1);
                    half_q <= '0;
                end
                ST_MEAS: begin
                    if (fe_hit || cnt_q == CNT_W'(MAX_HALF)) half_q <= cnt_q;
                    else                                      cnt_q  <= cnt_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_o   <= 1'b0;
            result_o <= '0;
        end else begin
            done_o   <= (nxt == ST_DONE);
            result_o <= (nxt == ST_DONE) ? fsk_encode(8'(half_q)) : '0;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MEAS) |-> (cnt_q <= CNT_W'(MAX_HALF))); // R7
    AST_ARM_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SYNC && $past(state) == ST_IDLE) |-> $past(arm_qual)); // R2
    AST_DONE_AT_REF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(ref_hit)); // R6
    AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(start_i) |=> !done_o); // R8
    AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (result_o[10:3] == 8'h00 && result_o[2:0] <= 3'd4)); // R5
    AST_ZERO_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> (result_o == '0)); // R9
endmodule

// File: tb/sim_frame_skew_meter.sv
module sim_frame_skew_meter;
    localparam int FRAME = 1024;
    localparam int MAXH  = 9;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        frame_i = 1'b1, fe_i = 1'b1, gci_i = 1'b0, start_i = 1'b0;
    logic        done_o;
    logic [11:0] result_o;

    int    total = 0, bad = 0, cyc = 0;
    string cur_req = "R1";

    int ph = 0, fe_off = 3;
    bit fe_en = 1'b1;

    always #5 clk = ~clk;

    frame_skew_meter #(.FRAME_TICKS(FRAME), .MAX_HALF(MAXH)) u0 (
        .clk(clk), .rst_n(rst_n), .frame_i(frame_i), .fe_i(fe_i),
        .gci_i(gci_i), .start_i(start_i), .done_o(done_o), .result_o(result_o));

    function automatic logic [11:0] exp_code(input int d);
        logic [11:0] r;
        r = 12'h000;
        r[2:0] = 3'(d / 2);
        r[11]  = (d % 2 == 0);
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [11:0] act, input logic [11:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // stimulus waveform: frame pulse 2 ticks wide, strobe 5 ticks wide
    always @(negedge clk) begin
        bit fa, ea;
        ph = (ph + 1) % FRAME;
        fa = (ph < 2);
        ea = fe_en && ((((ph - fe_off) % FRAME) + FRAME) % FRAME < 5);
        frame_i <= gci_i ? fa : !fa;
        fe_i    <= gci_i ? ea : !ea;
    end

    // behavioural reference: timestamps of events since the accepted start
    bit          m_started = 0, pf = 0, pe = 0, ps = 0, m_done = 0;
    int          m_r1 = -1, m_r2 = -1, m_fe = -1, m_low = 0, now = 0;
    logic [11:0] m_res = 12'h000;

    always @(posedge clk) begin
        bit rh, eh;
        int d;
        if (!rst_n) begin
            m_started = 0; pf = 0; pe = 0; ps = 0; m_low = 0;
            m_done = 0; m_res = 12'h000;
        end else begin
            rh = gci_i ? (frame_i && !pf) : (!frame_i && pf);
            eh = gci_i ? (fe_i && !pe) : (!fe_i && pe);
            if (!start_i) m_started = 0;
            else if (!ps && m_low >= FRAME) begin
                m_started = 1; m_r1 = -1; m_r2 = -1; m_fe = -1;
            end else if (m_started) begin
                if (rh && m_r1 < 0) m_r1 = now;
                else if (rh && m_r2 < 0) m_r2 = now;
                if (eh && m_r1 >= 0 && m_fe < 0) m_fe = now;
            end
            m_low = start_i ? 0 : ((m_low < FRAME) ? m_low + 1 : FRAME);
            pf = frame_i; pe = fe_i; ps = start_i;
            now++;
            m_done = m_started && (m_r2 >= 0);
            d = (m_fe >= 0 && m_fe - m_r1 <= MAXH) ? m_fe - m_r1 : MAXH;
            m_res = m_done ? exp_code(d) : 12'h000;
        end
    end

    // per-tick comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk(done_o === m_done, {cur_req, " flag vs model"}, {11'h0, done_o}, {11'h0, m_done});
            chk(result_o === m_res, {cur_req, " code vs model"}, result_o, m_res);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            bad++;
            $display("FAIL R1 watchdog cycles=%0d expected=%0d", cyc, 190000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic meas(input bit g, input int off, input bit en, input string req, input logic [11:0] exp);
        @(negedge clk);
        cur_req = req; gci_i = g; fe_off = off; fe_en = en; start_i = 1'b0;
        repeat (FRAME + 4) @(negedge clk);
        start_i = 1'b1;
        repeat (3 * FRAME) @(negedge clk);
        chk(done_o === 1'b1, {req, " R6 flag after two frames"}, {11'h0, done_o}, 12'h001);
        chk(result_o === exp, {req, " coded delay"}, result_o, exp);
        start_i = 1'b0;
        @(negedge clk);
        chk(done_o === 1'b0 && result_o === 12'h000, "R8 clear on start low", result_o, 12'h000);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(done_o === 1'b0 && result_o === 12'h000, "R1 during reset", result_o, 12'h000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done_o === 1'b0 && result_o === 12'h000, "R1 after reset", result_o, 12'h000);

        meas(0, 0,  1, "R4 zero delay",        12'h800);
        meas(0, 1,  1, "R5 one half",          12'h000);
        meas(0, 3,  1, "R5 three halves",      12'h001);
        meas(0, 8,  1, "R4 eight halves",      12'h804);
        meas(0, 9,  1, "R7 window edge",       12'h004);
        meas(0, 12, 1, "R7 late strobe",       12'h004);
        meas(0, 0,  0, "R7 no strobe",         12'h004);
        meas(0, FRAME - 3, 1, "R4 early strobe ignored", 12'h004);
        meas(1, 5,  1, "R3 rising format d5",  12'h002);
        meas(1, 0,  1, "R3 rising format d0",  12'h800);

        // R2: short low period does not start a measurement
        @(negedge clk);
        cur_req = "R2"; gci_i = 0; fe_off = 2; fe_en = 1; start_i = 1'b0;
        repeat (20) @(negedge clk);
        start_i = 1'b1;
        repeat (3 * FRAME) @(negedge clk);
        chk(done_o === 1'b0, "R2 unqualified start", {11'h0, done_o}, 12'h000);

        // R9: flag held while start high; short re-arm ignored
        cur_req = "R9"; start_i = 1'b0;
        repeat (FRAME + 4) @(negedge clk);
        start_i = 1'b1;
        repeat (3 * FRAME) @(negedge clk);
        chk(done_o === 1'b1 && result_o === 12'h801, "R9 done d2", result_o, 12'h801);
        repeat (FRAME) @(negedge clk);
        chk(done_o === 1'b1 && result_o === 12'h801, "R9 flag held", result_o, 12'h801);
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        start_i = 1'b1;
        repeat (3 * FRAME) @(negedge clk);
        chk(done_o === 1'b0 && result_o === 12'h000, "R9 rearm needs full low", result_o, 12'h000);

        // R8: abort in the middle of a measurement
        cur_req = "R8"; start_i = 1'b0;
        repeat (FRAME + 4) @(negedge clk);
        start_i = 1'b1;
        repeat (30) @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        start_i = 1'b1;
        repeat (3 * FRAME) @(negedge clk);
        chk(done_o === 1'b0 && result_o === 12'h000, "R8 aborted run", result_o, 12'h000);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule